// File: doc/BRIEF.md
# Sigma-Delta First-Integrator Leakage Self-Test Controller

This block is an on-chip test sequencer for a low-pass sigma-delta modulator. It feeds a short, repeating digital bit pattern whose mean is nonzero into the modulator's stimulus input. Over a window of N samples it sums the modulator's one-bit output, counting each bit as +1 or -1. It then runs a second window with every stimulus bit inverted. The two signed counts are then combined. Their difference is proportional to the integrator leakage. Their sum, with a 2N term taken off, carries the input-referred offset. The final division by the stimulus-dependent scale factor is left to software.

A run is started with a one-cycle `start` pulse. At that edge the pattern, its period, the number of whole periods to count, the settling length and the routing choice are all latched. Each phase begins with a settling interval. During that interval the stimulus is driven but the output bits are not counted. The window length is programmed as a number of whole pattern periods, so N is always a multiple of the period. A routing bit sends the stimulus either to the first-integrator input or directly to the second-integrator input, so the same procedure also measures the second integrator.

Top module: `leak_bist_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four result outputs go to 0, `busy` and `done` go low, and both stimulus outputs go to 0.
- R2: `start` is acted on only when the block is idle or done. A `start` pulse during a run, and any change to the configuration inputs during a run, have no effect on the timing, the stimulus or the results of that run.
- R3: Cycle 0 is the cycle after the accepting edge. With latched settle length S and window N, the block has S settle cycles, then N phase-A count cycles, then S settle cycles, then N phase-B count cycles, then one compute cycle. Then `done` is high and `busy` is low. `busy` is high from cycle 0 through the compute cycle. S = 0 removes both settle intervals.
- R4: Within a phase, the stimulus bit in its k-th cycle (k from 0, counted from the first settle cycle) is `pattern_in[k mod P]`. Bit 0 is used first. In phase B the bit is inverted. Outside the two phases the stimulus is 0.
- R5: With `route_int2` = 0 the stimulus appears on `stim_int1` and `stim_int2` is held at 0. With `route_int2` = 1 the two roles are swapped.
- R6: The effective period P is `period_in`, with 0 treated as 1 and values above PAT_W treated as PAT_W. The effective period count is `nper_in`, with 0 treated as 1. N = period count × P.
- R7: In each count cycle, `mod_bit` = 1 adds +1 and `mod_bit` = 0 adds -1 to the phase count. `mod_bit` in settle cycles has no effect.
- R8: After the compute cycle, `count_pos` = A and `count_neg` = B, where A is the phase-A count and B is the phase-B count. `diff_out` = A - B and `sum_out` = A + B - 2N. All four are two's-complement signed.
- R9: At the largest N (255 periods of 16 bits), all-ones or all-zeros output bits give exact results with no wrap. The extreme case is `sum_out` = -16320.
- R10: The result outputs change only at the end of a compute cycle. They hold their values while done and throughout a following run until that run's compute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request, accepted when idle or done |
| pattern_in | input | PAT_W | Stimulus bits, bit 0 played first |
| period_in | input | PER_W | Pattern period in bits |
| nper_in | input | NPER_W | Number of whole periods per count window |
| settle_in | input | SET_W | Settle cycles before each window |
| route_int2 | input | 1 | 1 = drive the second-integrator stimulus input |
| mod_bit | input | 1 | Modulator output bitstream |
| stim_int1 | output | 1 | Stimulus to the first-integrator input |
| stim_int2 | output | 1 | Stimulus to the second-integrator input |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid, block ready |
| count_pos | output | N_W+1 | Phase-A signed count |
| count_neg | output | N_W+1 | Phase-B signed count |
| diff_out | output | N_W+3 | A minus B |
| sum_out | output | N_W+3 | A plus B minus 2N |

## Verification
The bench uses the default sizes: a 16-bit pattern, an 8-bit period count and a 6-bit settle length. With these sizes the largest window of 4080 samples takes about 8200 cycles per run. That keeps the full-scale no-wrap case and the period clamps at 0 and above 16 within reach. A bench-side modulator model drives a biased value during settle cycles and, in count windows, echoes the stimulus, holds a constant, or plays a pseudo-random stream. Because the bench predicts the stimulus cycle by cycle, any phase or inversion slip also changes the counts it expects.

// File: rtl/lbist_pkg.sv
// Shared types for the leakage self-test controller.
package lbist_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETA,
        ST_CNTA,
        ST_SETB,
        ST_CNTB,
        ST_CALC,
        ST_DONE
    } lbist_state_e;
endpackage

// File: rtl/lbist_seq.sv
// Run sequencer: steps through settle, count A, settle, count B, compute, done.
// Assumes total_* >= 1; settle of 0 skips the settle state.
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int N_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SET_W-1:0] settle_live,
    input  logic [N_W-1:0]   total_live,
    input  logic [SET_W-1:0] settle_held,
    input  logic [N_W-1:0]   total_held,
    output lbist_state_e     state,
    output logic             go,
    output logic             end_a
);
    logic [SET_W-1:0] settle_left;
    logic [N_W-1:0]   samp_left;

    // accept a request only when no run is in progress
    always_comb go = start && (state == ST_IDLE || state == ST_DONE);
    // last sample of window A
    always_comb end_a = (state == ST_CNTA) && (samp_left == N_W'(1));

    // state and interval counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            settle_left <= '0;
            samp_left   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        settle_left <= settle_live;
                        samp_left   <= total_live;
                        state       <= (settle_live != '0) ? ST_SETA : ST_CNTA;
                    end
                end
                ST_SETA, ST_SETB: begin
                    if (settle_left == SET_W'(1)) begin
                        state <= (state == ST_SETA) ? ST_CNTA : ST_CNTB;
                    end else begin
                        settle_left <= settle_left - SET_W'(1);
                    end
                end
                ST_CNTA: begin
                    if (samp_left == N_W'(1)) begin
                        settle_left <= settle_held;
                        samp_left   <= total_held;
                        state       <= (settle_held != '0) ? ST_SETB : ST_CNTB;
                    end else begin
                        samp_left <= samp_left - N_W'(1);
                    end
                end
                ST_CNTB: begin
                    if (samp_left == N_W'(1)) state <= ST_CALC;
                    else samp_left <= samp_left - N_W'(1);
                end
                ST_CALC: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    calc_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CALC |=> state == ST_DONE);

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_DONE && state != ST_CALC && start)
            |=> (state != ST_IDLE && state != ST_DONE));
endmodule

// File: rtl/lbist_stim.sv
// Stimulus player: walks the latched pattern modulo its period, inverts in
// phase B and routes the bit to one of two integrator inputs.
// Assumes period_q is in 1..PAT_W.
module lbist_stim #(
    parameter int PAT_W = 16,
    parameter int PER_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic             invert,
    input  logic             route_q,
    input  logic [PAT_W-1:0] pattern_q,
    input  logic [PER_W-1:0] period_q,
    output logic             stim_int1,
    output logic             stim_int2
);
    localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

    logic [IDX_W-1:0] idx;
    logic             bit_now;

    // pattern position, cleared at the start of each phase
    always_ff @(posedge clk) begin
        if (!rst_n || restart) idx <= '0;
        else if (active) idx <= (PER_W'(idx) == period_q - PER_W'(1)) ? '0 : idx + IDX_W'(1);
    end

    // current stimulus bit and its routing
    always_comb begin
        bit_now   = active && (pattern_q[idx] ^ invert);
        stim_int1 = bit_now && !route_q;
        stim_int2 = bit_now && route_q;
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> PER_W'(idx) < period_q);
endmodule

// File: rtl/lbist_accum.sv
// Signed +1/-1 accumulator for the modulator bitstream; clear has priority.
// Assumes the width holds the longest window.
module lbist_accum #(
    parameter int ACC_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] acc_next
);
    // value including the current sample
    always_comb acc_next = en ? acc + (bit_in ? ACC_W'(1) : {ACC_W{1'b1}}) : acc;

    // running count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else acc <= acc_next;
    end

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear) |=> (acc - $past(acc) == ACC_W'(1) || $past(acc) - acc == ACC_W'(1)));
endmodule

// File: rtl/leak_bist_ctrl.sv
// Integrator leakage self-test top: latches configuration at start, plays the
// stimulus twice (normal, inverted), counts the bitstream and forms results.
// Assumes mod_bit is synchronous to clk.
module leak_bist_ctrl
    import lbist_pkg::*;
#(
    parameter int PAT_W  = 16,
    parameter int NPER_W = 8,
    parameter int SET_W  = 6,
    localparam int PER_W = $clog2(PAT_W + 1),
    localparam int N_W   = $clog2(PAT_W) + NPER_W,
    localparam int ACC_W = N_W + 1,
    localparam int RES_W = N_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAT_W-1:0]        pattern_in,
    input  logic [PER_W-1:0]        period_in,
    input  logic [NPER_W-1:0]       nper_in,
    input  logic [SET_W-1:0]        settle_in,
    input  logic                    route_int2,
    input  logic                    mod_bit,
    output logic                    stim_int1,
    output logic                    stim_int2,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] count_pos,
    output logic signed [ACC_W-1:0] count_neg,
    output logic signed [RES_W-1:0] diff_out,
    output logic signed [RES_W-1:0] sum_out
);
    lbist_state_e             state;
    logic                     go, end_a;
    logic [PER_W-1:0]         period_eff, period_q;
    logic [NPER_W-1:0]        nper_eff;
    logic [N_W-1:0]           total_live, total_q;
    logic [SET_W-1:0]         settle_q;
    logic [PAT_W-1:0]         pattern_q;
    logic                     route_q;
    logic signed [ACC_W-1:0]  acc, acc_next, a_q;
    logic signed [RES_W-1:0]  a_ext, b_ext, two_n;

    // clamp the programmed period and period count
    always_comb begin
        if (period_in == '0) period_eff = PER_W'(1);
        else if (period_in > PER_W'(PAT_W)) period_eff = PER_W'(PAT_W);
        else period_eff = period_in;
        nper_eff   = (nper_in == '0) ? NPER_W'(1) : nper_in;
        total_live = N_W'(nper_eff) * N_W'(period_eff);
    end

    // configuration captured when a run is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= '0;
            period_q  <= PER_W'(1);
            total_q   <= N_W'(1);
            settle_q  <= '0;
            route_q   <= 1'b0;
        end else if (go) begin
            pattern_q <= pattern_in;
            period_q  <= period_eff;
            total_q   <= total_live;
            settle_q  <= settle_in;
            route_q   <= route_int2;
        end
    end

    lbist_seq #(.SET_W(SET_W), .N_W(N_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .settle_live(settle_in), .total_live(total_live),
        .settle_held(settle_q), .total_held(total_q),
        .state(state), .go(go), .end_a(end_a)
    );

    lbist_stim #(.PAT_W(PAT_W), .PER_W(PER_W)) u_stim (
        .clk(clk), .rst_n(rst_n), .restart(go || end_a),
        .active(state inside {ST_SETA, ST_CNTA, ST_SETB, ST_CNTB}),
        .invert(state inside {ST_SETB, ST_CNTB}),
        .route_q(route_q), .pattern_q(pattern_q), .period_q(period_q),
        .stim_int1(stim_int1), .stim_int2(stim_int2)
    );

    lbist_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(go || end_a),
        .en(state == ST_CNTA || state == ST_CNTB), .bit_in(mod_bit),
        .acc(acc), .acc_next(acc_next)
    );

    // handshake flags
    always_comb begin
        busy = state inside {ST_SETA, ST_CNTA, ST_SETB, ST_CNTB, ST_CALC};
        done = (state == ST_DONE);
    end

    // sign-extended operands for the result arithmetic
    always_comb begin
        a_ext = RES_W'(a_q);
        b_ext = RES_W'(acc);
        two_n = $signed({2'b00, total_q, 1'b0});
    end

    // phase-A count holding register
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else if (end_a) a_q <= acc_next;
    end

    // result registers, written only in the compute cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_pos <= '0;
            count_neg <= '0;
            diff_out  <= '0;
            sum_out   <= '0;
        end else if (state == ST_CALC) begin
            count_pos <= a_q;
            count_neg <= acc;
            diff_out  <= a_ext - b_ext;
            sum_out   <= a_ext + b_ext - two_n;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (RES_W'(acc) <= $signed({2'b00, total_q, 1'b0}) >>> 1
                  && RES_W'(acc) >= -($signed({2'b00, total_q, 1'b0}) >>> 1)));

    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_CALC |=> ($stable(count_pos) && $stable(count_neg)
                              && $stable(diff_out) && $stable(sum_out)));

    // R5
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q ? !stim_int1 : !stim_int2));
endmodule

// File: tb/sim_leak_bist_ctrl.sv
module sim_leak_bist_ctrl;
    localparam int CLK_NS = 10;
    localparam int PAT_W = 16, NPER_W = 8, SET_W = 6;
    localparam int PER_W = 5, N_W = 12, ACC_W = 13, RES_W = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PAT_W-1:0]  pattern_in = '0;
    logic [PER_W-1:0]  period_in = '0;
    logic [NPER_W-1:0] nper_in = '0;
    logic [SET_W-1:0]  settle_in = '0;
    logic route_int2 = 1'b0;
    logic mod_bit = 1'b0;
    logic stim_int1, stim_int2, busy, done;
    logic signed [ACC_W-1:0] count_pos, count_neg;
    logic signed [RES_W-1:0] diff_out, sum_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_NS/2) clk = ~clk;

    leak_bist_ctrl #(.PAT_W(PAT_W), .NPER_W(NPER_W), .SET_W(SET_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern_in(pattern_in),
        .period_in(period_in), .nper_in(nper_in), .settle_in(settle_in),
        .route_int2(route_int2), .mod_bit(mod_bit), .stim_int1(stim_int1),
        .stim_int2(stim_int2), .busy(busy), .done(done), .count_pos(count_pos),
        .count_neg(count_neg), .diff_out(diff_out), .sum_out(sum_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // mode: 0 echo stimulus, 1 constant one, 2 constant zero, 3 pseudo-random
    task automatic run_case(input string name, input logic [PAT_W-1:0] pat,
                            input int per, input int nper, input int settle,
                            input logic route, input int mode, input logic disturb);
        int p_eff, n_eff, n, s, last, exp_a, exp_b, stim_err, time_err, hold_err;
        int old_pos, old_neg, old_diff, old_sum;
        logic exp_bit, sel, other;
        p_eff = (per == 0) ? 1 : (per > PAT_W ? PAT_W : per);
        n_eff = (nper == 0) ? 1 : nper;
        n = n_eff * p_eff;
        s = settle;
        last = 2*s + 2*n;
        exp_a = 0; exp_b = 0; stim_err = 0; time_err = 0; hold_err = 0;
        old_pos = int'(count_pos); old_neg = int'(count_neg);
        old_diff = int'(diff_out); old_sum = int'(sum_out);
        pattern_in = pat; period_in = PER_W'(per); nper_in = NPER_W'(nper);
        settle_in = SET_W'(settle); route_int2 = route;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= last; k++) begin
            if (k < s + n) exp_bit = pat[k % p_eff];
            else if (k < last) exp_bit = ~pat[(k - s - n) % p_eff];
            else exp_bit = 1'b0;
            sel = route ? stim_int2 : stim_int1;
            other = route ? stim_int1 : stim_int2;
            if (sel !== exp_bit || other !== 1'b0) stim_err++;
            if (busy !== 1'b1 || done !== 1'b0) time_err++;
            if (int'(count_pos) != old_pos || int'(count_neg) != old_neg ||
                int'(diff_out) != old_diff || int'(sum_out) != old_sum) hold_err++;
            if ((k < s) || (k >= s + n && k < 2*s + n) || k == last) begin
                mod_bit = 1'b1;
            end else begin
                case (mode)
                    0: mod_bit = sel;
                    1: mod_bit = 1'b1;
                    2: mod_bit = 1'b0;
                    default: begin
                        mod_bit = lfsr[0];
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    end
                endcase
                if (k < s + n) exp_a += mod_bit ? 1 : -1;
                else exp_b += mod_bit ? 1 : -1;
            end
            if (disturb && k == 2) begin
                start = 1'b1; pattern_in = ~pat; period_in = 5'd7;
                nper_in = 8'd3; settle_in = 6'd1; route_int2 = ~route;
            end
            if (disturb && k == 3) start = 1'b0;
            @(negedge clk);
        end
        $display("case %s: N=%0d A=%0d B=%0d", name, n, exp_a, exp_b);
        check({"R4 R5 stimulus mismatches ", name}, stim_err, 0);
        check({"R3 busy/done during run ", name}, time_err, 0);
        check({"R10 results held during run ", name}, hold_err, 0);
        check({"R3 done after compute ", name}, int'({done, busy}), 2);
        check({"R8 count_pos ", name}, int'(count_pos), exp_a);
        check({"R8 count_neg ", name}, int'(count_neg), exp_b);
        check({"R8 diff_out ", name}, int'(diff_out), exp_a - exp_b);
        check({"R8 sum_out ", name}, int'(sum_out), exp_a + exp_b - 2*n);
        if (disturb) check({"R2 restart ignored, done once ", name}, int'(done), 1);
    endtask

    task automatic hold_test();
        int p0, p1, d0, s0, err;
        p0 = int'(count_pos); p1 = int'(count_neg);
        d0 = int'(diff_out); s0 = int'(sum_out); err = 0;
        for (int i = 0; i < 6; i++) begin
            mod_bit = i[0]; pattern_in = ~pattern_in; settle_in = SET_W'(i);
            @(negedge clk);
            if (int'(count_pos) != p0 || int'(count_neg) != p1 ||
                int'(diff_out) != d0 || int'(sum_out) != s0 || done !== 1'b1) err++;
        end
        check("R10 results stable while done", err, 0);
    endtask

    task automatic reset_test();
        repeat (3) @(negedge clk);
        check("R1 reset results", int'(count_pos) | int'(count_neg) | int'(diff_out) | int'(sum_out), 0);
        check("R1 reset flags", int'({busy, done, stim_int1, stim_int2}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        reset_test();
        run_case("R4 echo", 16'b0000_0000_0001_1011, 5, 4, 3, 1'b0, 0, 1'b0);
        hold_test();
        run_case("R5 route2 settle0", 16'h00F7, 8, 3, 0, 1'b1, 1, 1'b0);
        run_case("R7 random", 16'hB5A3, 16, 6, 7, 1'b0, 3, 1'b0);
        run_case("R6 period0", 16'h0001, 0, 5, 2, 1'b1, 0, 1'b0);
        run_case("R6 period31 nper0", 16'h3C0F, 31, 0, 4, 1'b0, 3, 1'b0);
        run_case("R2 disturb", 16'h0033, 6, 5, 4, 1'b0, 0, 1'b1);
        run_case("R9 full zero", 16'h7FFF, 16, 255, 2, 1'b0, 2, 1'b0);
        run_case("R9 full one", 16'h7FFF, 16, 255, 1, 1'b1, 1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule